// File: doc/BRIEF.md
# Serial Flash Identification and Geometry Probe

This block runs on its own once reset is released. It talks to a page-organised serial flash over a four-wire SPI link in mode 0: the clock idles low, data goes out most significant bit first, and input is sampled on the rising clock edge. It first reads the device identity and decides whether the part is one it can drive. If so, it works out the page size as a power-of-two exponent and the number of pages. It then polls the device status until the part reports ready. Last, it checks that the part is set up for power-of-two page sizes.

When the part is still in its non-binary page mode, the probe sends the fixed four-byte sequence that switches the page mode. It then reports that the part has to be power cycled before it can be used. The result is given once per reset: a single `probe_done` pulse, and with it either the success flag and the geometry or exactly one error bit. The rest of the system waits for that pulse before it starts normal flash traffic. A separate controller handles read, program and erase traffic.

Top module: `flash_id_probe`

## Requirements
- R1: While reset is asserted and whenever no transaction is open, `spi_cs_n` is high and `spi_sck` is low. The first window opened after reset is the identity read.
- R2: The identity read is one chip-select window of exactly four bytes. The first byte is opcode 0x9F. The next three bytes clock data in, and the first two of them are the manufacturer byte and the device byte.
- R3: The part is accepted only if the manufacturer byte is 0x1F and bits 7:5 of the device byte are 3'b001. Otherwise the result is `probe_err` = 4'b0001 and no further window is opened.
- R4: Bits 4:0 of the device byte set the geometry. Codes 0x02, 0x03, 0x04 and 0x05 give page_shift 8, with 512, 1024, 2048 and 4096 pages respectively.
- R5: Code 0x06 gives shift 9 with 4096 pages, code 0x07 gives shift 9 with 8192 pages, and code 0x08 gives shift 10 with 8192 pages.
- R6: Any other capacity code from an accepted family gives `probe_err` = 4'b0010, and no further window is opened.
- R7: After an accepted identity, the probe opens status windows of two bytes each: opcode 0xD7, then one byte read in. It keeps doing this until bit 7 of the status byte is 1. If the ready status comes on the last permitted attempt, the probe still succeeds.
- R8: If `poll_limit` status reads in a row all show bit 7 at 0, the result is `probe_err` = 4'b1000. A `poll_limit` of 0 allows one read. No window is opened after that.
- R9: If the ready status byte has bit 0 at 0, the probe sends one window of 0x3D, 0x2A, 0x80 and 0xA6. The result is then `probe_err` = 4'b0100 with `probe_ok` low.
- R10: `probe_done` pulses for one cycle, exactly once per reset. `probe_err` is one-hot or zero, and it is nonzero only during that pulse. On success, `probe_ok` rises with the pulse and stays high together with a stable geometry. Before that, the outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| poll_limit | input | POLL_W | Maximum number of status reads before timeout |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | SPI clock, idles low |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |
| probe_done | output | 1 | One-cycle completion pulse |
| probe_ok | output | 1 | Part accepted and ready; held until reset |
| page_shift | output | 4 | log2 of the page size in bytes, valid with probe_ok |
| page_count | output | PAGES_W | Number of pages, valid with probe_ok |
| probe_err | output | 4 | One-hot error: bit0 identity, bit1 capacity, bit2 page mode rewritten, bit3 poll timeout |

## Verification
The poll counter reaching its limit and the device turning ready can land on the same status read. The bench provokes this by having the device model report busy for exactly `poll_limit`-1 reads, then ready; the probe must succeed and not time out. It also makes the busy count equal the limit, where the timeout must win. A second overlap is a ready status whose page-mode bit is clear. Here the same status byte both ends the poll and triggers the rewrite. The bench judges this from the logged bytes of the following window and from the error bit, and it confirms that `probe_ok` stays low.

// File: rtl/flash_id_probe_pkg.sv
package flash_id_probe_pkg;

  typedef enum logic [2:0] {
    S_INIT, S_ID, S_IDCHK, S_POLL, S_POLLCHK, S_PGM, S_HALT
  } probe_state_e;

  localparam int ERR_W    = 4;
  localparam int ERR_ID   = 0;
  localparam int ERR_CAP  = 1;
  localparam int ERR_PGSZ = 2;
  localparam int ERR_TMO  = 3;

  localparam logic [7:0] OP_IDREAD = 8'h9F;
  localparam logic [7:0] OP_STATUS = 8'hD7;
  localparam logic [7:0] DUMMY     = 8'hFF;
  localparam logic [7:0] VENDOR_ID = 8'h1F;
  localparam logic [2:0] FAMILY_ID = 3'b001;

  // bytes of the page-mode rewrite window, sent in this order
  function automatic logic [7:0] pgm_byte(input logic [1:0] idx);
    case (idx)
      2'd0:    pgm_byte = 8'h3D;
      2'd1:    pgm_byte = 8'h2A;
      2'd2:    pgm_byte = 8'h80;
      default: pgm_byte = 8'hA6;
    endcase
  endfunction

endpackage

// File: rtl/flash_id_probe_spi_byte.sv
module flash_id_probe_spi_byte #(
  parameter int SCK_HALF = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_i,
  input  logic [7:0] tx_byte_i,
  input  logic       miso_i,
  output logic       sck_o,
  output logic       mosi_o,
  output logic       busy_o,
  output logic       done_o,
  output logic [7:0] rx_byte_o
);
  localparam int CW = (SCK_HALF > 1) ? $clog2(SCK_HALF) : 1;

  logic          busy_q, busy_d, sck_q, sck_d, done_q, done_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [2:0]    bit_q, bit_d;
  logic [7:0]    tx_q, tx_d, rx_q, rx_d;

  always_comb begin
    busy_d = busy_q; sck_d = sck_q; cnt_d = cnt_q; bit_d = bit_q;
    tx_d   = tx_q;   rx_d  = rx_q;  done_d = 1'b0;
    if (!busy_q) begin
      if (start_i) begin
        busy_d = 1'b1; tx_d = tx_byte_i; bit_d = '0; cnt_d = '0; sck_d = 1'b0;
      end
    end else if (cnt_q == CW'(SCK_HALF - 1)) begin
      cnt_d = '0;
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[6:0], miso_i};
      end else begin
        sck_d = 1'b0;
        if (bit_q == 3'd7) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 3'd1;
          tx_d  = {tx_q[6:0], 1'b0};
        end
      end
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0; sck_q <= 1'b0; done_q <= 1'b0;
      cnt_q  <= '0;   bit_q <= '0;   tx_q   <= '0; rx_q <= '0;
    end else begin
      busy_q <= busy_d; sck_q <= sck_d; done_q <= done_d;
      cnt_q  <= cnt_d;  bit_q <= bit_d; tx_q   <= tx_d; rx_q <= rx_d;
    end
  end

  assign sck_o     = sck_q;
  assign mosi_o    = tx_q[7] & busy_q;
  assign busy_o    = busy_q;
  assign done_o    = done_q;
  assign rx_byte_o = rx_q;
endmodule

// File: rtl/flash_id_probe_geo.sv
module flash_id_probe_geo #(
  parameter int PAGES_W = 14
) (
  input  logic [4:0]         cap_i,
  output logic               known_o,
  output logic [3:0]         shift_o,
  output logic [PAGES_W-1:0] pages_o
);
  logic [3:0] log2p;

  always_comb begin
    known_o = 1'b1;
    shift_o = 4'd8;
    log2p   = 4'd9;
    case (cap_i)
      5'h02, 5'h03, 5'h04, 5'h05: begin
        shift_o = 4'd8;
        log2p   = 4'(cap_i) + 4'd7;
      end
      5'h06: begin shift_o = 4'd9;  log2p = 4'd12; end
      5'h07: begin shift_o = 4'd9;  log2p = 4'd13; end
      5'h08: begin shift_o = 4'd10; log2p = 4'd13; end
      default: known_o = 1'b0;
    endcase
    pages_o = PAGES_W'(1) << log2p;
  end
endmodule

// File: rtl/flash_id_probe.sv
module flash_id_probe
  import flash_id_probe_pkg::*;
#(
  parameter int SCK_HALF = 2,
  parameter int POLL_W   = 8,
  parameter int PAGES_W  = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [POLL_W-1:0]  poll_limit,
  output logic               spi_cs_n,
  output logic               spi_sck,
  output logic               spi_mosi,
  input  logic               spi_miso,
  output logic               probe_done,
  output logic               probe_ok,
  output logic [3:0]         page_shift,
  output logic [PAGES_W-1:0] page_count,
  output logic [ERR_W-1:0]   probe_err
);
  probe_state_e       state_q, state_d;
  logic [1:0]         idx_q, idx_d;
  logic [POLL_W-1:0]  att_q, att_d;
  logic [7:0]         mfr_q, dev_q;
  logic               rdy_q, pgbin_q;
  logic               cs_n_q, done_q, ok_q;
  logic [ERR_W-1:0]   err_q, err_n;
  logic [3:0]         shift_q;
  logic [PAGES_W-1:0] pages_q;
  logic               fin, fin_ok, xfer_now, xfer_next;
  logic               eng_start, eng_busy, eng_done;
  logic [7:0]         eng_tx, eng_rx;
  logic               geo_known;
  logic [3:0]         geo_shift;
  logic [PAGES_W-1:0] geo_pages;

  flash_id_probe_spi_byte #(.SCK_HALF(SCK_HALF)) u_eng (
    .clk(clk), .rst_n(rst_n), .start_i(eng_start), .tx_byte_i(eng_tx),
    .miso_i(spi_miso), .sck_o(spi_sck), .mosi_o(spi_mosi),
    .busy_o(eng_busy), .done_o(eng_done), .rx_byte_o(eng_rx)
  );

  flash_id_probe_geo #(.PAGES_W(PAGES_W)) u_geo (
    .cap_i(dev_q[4:0]), .known_o(geo_known),
    .shift_o(geo_shift), .pages_o(geo_pages)
  );

  assign xfer_now  = (state_q == S_ID) || (state_q == S_POLL) || (state_q == S_PGM);
  assign xfer_next = (state_d == S_ID) || (state_d == S_POLL) || (state_d == S_PGM);
  assign eng_start = xfer_now && !eng_busy && !eng_done;

  always_comb begin
    case (state_q)
      S_ID:    eng_tx = (idx_q == 2'd0) ? OP_IDREAD : DUMMY;
      S_POLL:  eng_tx = (idx_q == 2'd0) ? OP_STATUS : DUMMY;
      S_PGM:   eng_tx = pgm_byte(idx_q);
      default: eng_tx = DUMMY;
    endcase
  end

  always_comb begin
    state_d = state_q; idx_d = idx_q; att_d = att_q;
    fin = 1'b0; fin_ok = 1'b0; err_n = '0;
    case (state_q)
      S_INIT: begin state_d = S_ID; idx_d = '0; end
      S_ID: if (eng_done) begin
        if (idx_q == 2'd3) state_d = S_IDCHK;
        else               idx_d   = idx_q + 2'd1;
      end
      S_IDCHK: begin
        if (mfr_q != VENDOR_ID || dev_q[7:5] != FAMILY_ID) begin
          fin = 1'b1; err_n[ERR_ID] = 1'b1; state_d = S_HALT;
        end else if (!geo_known) begin
          fin = 1'b1; err_n[ERR_CAP] = 1'b1; state_d = S_HALT;
        end else begin
          state_d = S_POLL; idx_d = '0; att_d = '0;
        end
      end
      S_POLL: if (eng_done) begin
        if (idx_q == 2'd1) state_d = S_POLLCHK;
        else               idx_d   = idx_q + 2'd1;
      end
      S_POLLCHK: begin
        if (rdy_q) begin
          if (pgbin_q) begin
            fin = 1'b1; fin_ok = 1'b1; state_d = S_HALT;
          end else begin
            state_d = S_PGM; idx_d = '0;
          end
        end else if ({1'b0, att_q} + 1'b1 >= {1'b0, poll_limit}) begin
          fin = 1'b1; err_n[ERR_TMO] = 1'b1; state_d = S_HALT;
        end else begin
          att_d = att_q + 1'b1; state_d = S_POLL; idx_d = '0;
        end
      end
      S_PGM: if (eng_done) begin
        if (idx_q == 2'd3) begin
          fin = 1'b1; err_n[ERR_PGSZ] = 1'b1; state_d = S_HALT;
        end else begin
          idx_d = idx_q + 2'd1;
        end
      end
      default: state_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_INIT; idx_q <= '0; att_q <= '0;
      mfr_q <= '0; dev_q <= '0; rdy_q <= 1'b0; pgbin_q <= 1'b0;
      cs_n_q <= 1'b1; done_q <= 1'b0; ok_q <= 1'b0; err_q <= '0;
      shift_q <= '0; pages_q <= '0;
    end else begin
      state_q <= state_d;
      idx_q   <= idx_d;
      att_q   <= att_d;
      cs_n_q  <= !xfer_next;
      done_q  <= fin;
      err_q   <= err_n;
      if (eng_done && state_q == S_ID && idx_q == 2'd1) mfr_q <= eng_rx;
      if (eng_done && state_q == S_ID && idx_q == 2'd2) dev_q <= eng_rx;
      if (eng_done && state_q == S_POLL && idx_q == 2'd1) begin
        rdy_q   <= eng_rx[7];
        pgbin_q <= eng_rx[0];
      end
      if (fin_ok) begin
        ok_q    <= 1'b1;
        shift_q <= geo_shift;
        pages_q <= geo_pages;
      end
    end
  end

  assign spi_cs_n   = cs_n_q;
  assign probe_done = done_q;
  assign probe_ok   = ok_q;
  assign page_shift = shift_q;
  assign page_count = pages_q;
  assign probe_err  = err_q;
endmodule

// File: rtl/flash_id_probe_chk.sv
module flash_id_probe_chk #(
  parameter int PAGES_W = 14
) (
  input logic               clk,
  input logic               rst_n,
  input logic               spi_cs_n,
  input logic               spi_sck,
  input logic               probe_done,
  input logic               probe_ok,
  input logic [3:0]         page_shift,
  input logic [PAGES_W-1:0] page_count,
  input logic [3:0]         probe_err
);
  logic seen_done;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          seen_done <= 1'b0;
    else if (probe_done) seen_done <= 1'b1;
  end

  a_r1_sck_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  a_r10_err_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(probe_err));

  a_r10_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    (probe_err != 4'b0000) |-> probe_done);

  a_r10_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    probe_done |-> !seen_done);

  a_r10_ok_held: assert property (@(posedge clk) disable iff (!rst_n)
    probe_ok |=> probe_ok && $stable(page_shift) && $stable(page_count));

  a_r10_ok_excl_err: assert property (@(posedge clk) disable iff (!rst_n)
    probe_ok |-> (probe_err == 4'b0000));

  a_r8_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
    seen_done |-> spi_cs_n);

  a_r5_shift_range: assert property (@(posedge clk) disable iff (!rst_n)
    probe_ok |-> (page_shift >= 4'd8 && page_shift <= 4'd10));
endmodule

bind flash_id_probe flash_id_probe_chk #(.PAGES_W(PAGES_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
  .probe_done(probe_done), .probe_ok(probe_ok), .page_shift(page_shift),
  .page_count(page_count), .probe_err(probe_err)
);

// File: tb/flash_id_probe_bench.sv
module flash_id_probe_bench;
  localparam int PAGES_W = 14;
  localparam int NV      = 14;

  typedef struct packed {
    logic [7:0]  id0;
    logic [7:0]  id1;
    logic [7:0]  busy;
    logic        pg;
    logic [7:0]  lim;
    logic [3:0]  err;
    logic [3:0]  sh;
    logic [13:0] pages;
  } vec_t;

  localparam vec_t VECS [NV] = '{
    '{8'h1F, 8'h22, 8'd0, 1'b1, 8'd4, 4'b0000, 4'd8,  14'd512},   // R4
    '{8'h1F, 8'h23, 8'd2, 1'b1, 8'd4, 4'b0000, 4'd8,  14'd1024},  // R4 R7
    '{8'h1F, 8'h24, 8'd0, 1'b1, 8'd4, 4'b0000, 4'd8,  14'd2048},  // R4
    '{8'h1F, 8'h25, 8'd1, 1'b1, 8'd4, 4'b0000, 4'd8,  14'd4096},  // R4
    '{8'h1F, 8'h26, 8'd0, 1'b1, 8'd4, 4'b0000, 4'd9,  14'd4096},  // R5
    '{8'h1F, 8'h27, 8'd0, 1'b1, 8'd4, 4'b0000, 4'd9,  14'd8192},  // R5
    '{8'h1F, 8'h28, 8'd3, 1'b1, 8'd4, 4'b0000, 4'd10, 14'd8192},  // R5 R7 last attempt
    '{8'h1E, 8'h26, 8'd0, 1'b1, 8'd4, 4'b0001, 4'd0,  14'd0},     // R3 vendor
    '{8'h1F, 8'h46, 8'd0, 1'b1, 8'd4, 4'b0001, 4'd0,  14'd0},     // R3 family
    '{8'h1F, 8'h29, 8'd0, 1'b1, 8'd4, 4'b0010, 4'd0,  14'd0},     // R6
    '{8'h1F, 8'h21, 8'd0, 1'b1, 8'd4, 4'b0010, 4'd0,  14'd0},     // R6
    '{8'h1F, 8'h26, 8'd4, 1'b1, 8'd4, 4'b1000, 4'd0,  14'd0},     // R8 limit reached
    '{8'h1F, 8'h26, 8'd1, 1'b1, 8'd0, 4'b1000, 4'd0,  14'd0},     // R8 limit zero
    '{8'h1F, 8'h27, 8'd1, 1'b0, 8'd4, 4'b0100, 4'd0,  14'd0}      // R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] poll_limit = 8'd4;
  logic spi_cs_n, spi_sck, spi_mosi;
  logic spi_miso = 1'b0;
  logic probe_done, probe_ok;
  logic [3:0] page_shift, probe_err;
  logic [PAGES_W-1:0] page_count;

  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  flash_id_probe #(.SCK_HALF(2), .POLL_W(8), .PAGES_W(PAGES_W)) u_flash_id_probe (
    .clk(clk), .rst_n(rst_n), .poll_limit(poll_limit),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .probe_done(probe_done), .probe_ok(probe_ok),
    .page_shift(page_shift), .page_count(page_count), .probe_err(probe_err)
  );

  // flash device model, evaluated on the falling system clock edge
  logic [7:0] m_id0 = 8'h1F, m_id1 = 8'h26;
  int         m_busy_init = 0;
  logic       m_pg = 1'b1;
  logic       m_clr = 1'b0;
  int         busy_left = 0, tr_cnt = 0, poll_cnt = 0, id_len = 0, pg_len = 0;
  int         byte_idx = 0, bit_cnt = 0;
  logic [7:0] sh_in = 8'h00, opcode = 8'h00, first_op = 8'h00;
  logic [7:0] log_b [0:7];
  logic [7:0] pg_b  [0:3];
  logic       cs_prev = 1'b1, sck_prev = 1'b0;

  function automatic logic [7:0] resp(input int idx);
    if (idx == 0) return 8'h00;
    if (opcode == 8'h9F) begin
      if (idx == 1) return m_id0;
      if (idx == 2) return m_id1;
      return 8'h5A;
    end
    if (opcode == 8'hD7) return {(busy_left == 0), 6'b010101, m_pg};
    return 8'h00;
  endfunction

  always @(negedge clk) begin
    if (m_clr) begin
      tr_cnt = 0; poll_cnt = 0; id_len = 0; pg_len = 0; first_op = 8'h00;
      busy_left = m_busy_init; byte_idx = 0; bit_cnt = 0;
    end else begin
      if (cs_prev && !spi_cs_n) begin
        bit_cnt = 0; byte_idx = 0; spi_miso = 1'b0;
      end else if (!spi_cs_n && !sck_prev && spi_sck) begin
        sh_in = {sh_in[6:0], spi_mosi};
        bit_cnt++;
        if (bit_cnt == 8) begin
          if (byte_idx == 0) opcode = sh_in;
          if (byte_idx < 8) log_b[byte_idx] = sh_in;
          byte_idx++;
          bit_cnt = 0;
        end
      end else if (!spi_cs_n && sck_prev && !spi_sck) begin
        spi_miso = resp(byte_idx) >> (7 - bit_cnt);
      end
      if (!cs_prev && spi_cs_n && byte_idx > 0) begin
        tr_cnt++;
        if (tr_cnt == 1) first_op = opcode;
        if (opcode == 8'h9F) id_len = byte_idx;
        if (opcode == 8'hD7) begin
          poll_cnt++;
          if (busy_left > 0) busy_left--;
        end
        if (opcode == 8'h3D) begin
          pg_len = byte_idx;
          for (int k = 0; k < 4; k++) pg_b[k] = log_b[k];
        end
      end
    end
    cs_prev  = spi_cs_n;
    sck_prev = spi_sck;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R10 watchdog expired actual=0 expected=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int v = 0; v < NV; v++) begin
      vec_t t = VECS[v];
      int   lim_eff, exp_polls, tr_snap, extra_done;
      bit   got;
      rst_n = 1'b0; m_clr = 1'b1;
      m_id0 = t.id0; m_id1 = t.id1; m_busy_init = int'(t.busy); m_pg = t.pg;
      poll_limit = t.lim;
      repeat (4) @(negedge clk);
      // R1 and R10: idle outputs while in reset
      check(spi_cs_n === 1'b1 && spi_sck === 1'b0, "R1", "idle bus in reset",
            {spi_cs_n, spi_sck}, 2'b10);
      check(probe_done === 1'b0 && probe_ok === 1'b0 && probe_err === 4'b0 &&
            page_count === '0, "R10", "outputs in reset",
            {probe_done, probe_ok, probe_err}, 0);
      m_clr = 1'b0;
      rst_n = 1'b1;
      got = 1'b0;
      for (int c = 0; c < 20000 && !got; c++) begin
        @(negedge clk);
        if (probe_done === 1'b1) got = 1'b1;
      end
      check(got, "R10", "done pulse seen", got, 1);
      check(probe_err === t.err, t.err == 0 ? "R7" :
            (t.err[0] ? "R3" : (t.err[1] ? "R6" : (t.err[2] ? "R9" : "R8"))),
            "error code", probe_err, t.err);
      check(probe_ok === (t.err == 0), "R10", "ok flag", probe_ok, t.err == 0);
      if (t.err == 0)
        check(page_shift === t.sh && page_count === t.pages,
              (t.sh == 4'd8) ? "R4" : "R5", "geometry",
              {page_shift, page_count}, {t.sh, t.pages});
      // R2: identity read window first, four bytes
      check(first_op === 8'h9F && id_len == 4, "R2", "identity window",
            {first_op, 8'(id_len)}, {8'h9F, 8'd4});
      // R7 and R8: number of status windows
      lim_eff = (t.lim == 0) ? 1 : int'(t.lim);
      if (t.err[0] || t.err[1])      exp_polls = 0;
      else if (int'(t.busy) < lim_eff) exp_polls = int'(t.busy) + 1;
      else                           exp_polls = lim_eff;
      check(poll_cnt == exp_polls, t.err[3] ? "R8" : "R7", "status reads",
            poll_cnt, exp_polls);
      // R9: rewrite window contents
      if (t.err[2])
        check(pg_len == 4 && pg_b[0] == 8'h3D && pg_b[1] == 8'h2A &&
              pg_b[2] == 8'h80 && pg_b[3] == 8'hA6, "R9", "rewrite bytes",
              {pg_b[0], pg_b[1], pg_b[2], pg_b[3]}, 32'h3D2A80A6);
      else
        check(pg_len == 0, "R9", "no rewrite window", pg_len, 0);
      // R10 and R8: silence after completion
      tr_snap = tr_cnt;
      extra_done = 0;
      for (int c = 0; c < 200; c++) begin
        @(negedge clk);
        if (probe_done === 1'b1) extra_done++;
      end
      check(extra_done == 0 && probe_err === 4'b0, "R10", "single pulse",
            extra_done, 0);
      check(tr_cnt == tr_snap && spi_cs_n === 1'b1, "R8", "no later windows",
            tr_cnt, tr_snap);
      if (t.err == 0)
        check(probe_ok === 1'b1 && page_shift === t.sh, "R10", "ok held",
              probe_ok, 1);
    end

    // directed: reset in the middle of a long status poll
    rst_n = 1'b0; m_clr = 1'b1; m_id0 = 8'h1F; m_id1 = 8'h26;
    m_busy_init = 50; m_pg = 1'b1; poll_limit = 8'd60;
    repeat (3) @(negedge clk);
    m_clr = 1'b0; rst_n = 1'b1;
    repeat (400) @(negedge clk);
    check(poll_cnt > 0 && probe_done === 1'b0, "R7", "poll under way",
          poll_cnt, 1);
    rst_n = 1'b0;
    @(negedge clk);
    check(spi_cs_n === 1'b1 && spi_sck === 1'b0 && probe_ok === 1'b0,
          "R1", "bus released on reset", {spi_cs_n, spi_sck}, 2'b10);
    m_clr = 1'b1;
    repeat (2) @(negedge clk);
    m_clr = 1'b0; m_busy_init = 0; rst_n = 1'b1;
    for (int c = 0; c < 20000 && probe_done !== 1'b1; c++) @(negedge clk);
    check(probe_ok === 1'b1 && page_shift === 4'd9 && page_count === 14'd4096,
          "R5", "probe after reset", {page_shift, page_count}, {4'd9, 14'd4096});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule